// File: doc/BRIEF.md
# Chained Magnitude Comparator

This block compares two unsigned operands and reports whether the first is greater than, equal to, or less than the second. It is built from identical 4-bit slices. Each slice compares its own bits and merges that result with a three-wire verdict that arrives from the slice below it. A local difference decides the slice's output. When the local bits are equal, the verdict from below is passed through. The slices are chained from the least significant to the most significant, so the verdict that leaves the top slice covers the full width.

The default configuration chains three slices into a 12-bit comparator. The verdict that enters the bottom slice is a port of the top module, so the whole comparator can be extended by another instance. When the block is used on its own, these inputs are tied to "equal": greater low, equal high, less low. The block is purely combinational.

Top module: `mcmp_chain`

## Requirements
- R1: When `opa_i` is greater than `opb_i` as an unsigned 12-bit number, `gt_o`=1, `eq_o`=0 and `lt_o`=0, whatever the cascade inputs are.
- R2: When `opa_i` is less than `opb_i` as an unsigned 12-bit number, `lt_o`=1, `gt_o`=0 and `eq_o`=0, whatever the cascade inputs are.
- R3: When `opa_i` equals `opb_i`, each output copies its cascade input: `gt_o`=`cas_gt_i`, `eq_o`=`cas_eq_i` and `lt_o`=`cas_lt_i`. This holds for all eight input patterns.
- R4: `eq_o` is never 1 while the two operands differ.
- R5: Whenever exactly one of the three cascade inputs is 1, exactly one of the three outputs is 1.
- R6: With the cascade inputs tied to greater=0, equal=1, less=0, the outputs give the plain unsigned comparison. A difference in a more significant slice overrides any difference in a less significant slice.
- R7: Operands that differ only in bit 0 are resolved correctly. So are operands that differ only in the top bit of a slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 12 | Operand A, unsigned |
| opb_i | input | 12 | Operand B, unsigned |
| cas_gt_i | input | 1 | Greater-than verdict from a lower chain; tie 0 when unused |
| cas_eq_i | input | 1 | Equal verdict from a lower chain; tie 1 when unused |
| cas_lt_i | input | 1 | Less-than verdict from a lower chain; tie 0 when unused |
| gt_o | output | 1 | A is greater than B |
| eq_o | output | 1 | A equals B and the lower verdict was equal |
| lt_o | output | 1 | A is less than B |

## Verification
The bench applies pairs whose two halves disagree: a lower slice says one direction and a higher slice says the other. A chain wired in the wrong order, or a slice that lets its cascade input override a local difference, would report the lower slice's verdict. Pairs that differ only in bit 0, or only at a slice's top bit, catch a compare chain that drops its last or first stage. Equal operands are driven with all eight cascade patterns, including patterns that are not one-hot. A merge that forces `eq_o` high, or that ignores the incoming greater or less wire, then gives a wrong output. Zero is compared against the maximum value in both directions.

// File: rtl/mcmp_pkg.sv
// Shared types for the chained magnitude comparator.
package mcmp_pkg;
    // Three-wire comparison verdict passed between slices.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } verdict_t;

    // Verdict that means "no decision yet, everything below is equal".
    localparam verdict_t VERDICT_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/mcmp_local.sv
// Local unsigned compare of two W-bit fields.
// Decides from the MSB down: the highest differing bit wins.
// Assumes W >= 1. Purely combinational.
module mcmp_local #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         gt_o,
    output logic         eq_o,
    output logic         lt_o
);
    // Index k holds the verdict over bits W-1 down to k.
    logic [W:0] gt_c;
    logic [W:0] lt_c;
    logic [W:0] eq_c;

    assign gt_c[W] = 1'b0;
    assign lt_c[W] = 1'b0;
    assign eq_c[W] = 1'b1;

    // One stage per bit: a decision is made only while all higher bits are equal.
    for (genvar k = W - 1; k >= 0; k--) begin : g_bit
        assign gt_c[k] = gt_c[k+1] | (eq_c[k+1] & a_i[k] & ~b_i[k]);
        assign lt_c[k] = lt_c[k+1] | (eq_c[k+1] & ~a_i[k] & b_i[k]);
        assign eq_c[k] = eq_c[k+1] & ~(a_i[k] ^ b_i[k]);
    end

    assign gt_o = gt_c[0];
    assign lt_o = lt_c[0];
    assign eq_o = eq_c[0];

    // Check the bit chain against the arithmetic compare.
    always_comb begin
        a_r1_local_gt: assert (gt_o == (a_i > b_i));
        a_r2_local_lt: assert (lt_o == (a_i < b_i));
    end
endmodule

// File: rtl/mcmp_merge.sv
// Merges a local verdict with the verdict from the slice below.
// A local difference wins. Local equality passes the lower verdict through.
module mcmp_merge
    import mcmp_pkg::*;
(
    input  logic     loc_gt_i,
    input  logic     loc_eq_i,
    input  logic     loc_lt_i,
    input  verdict_t below_i,
    output verdict_t out_o
);
    // Combine the local result with the incoming verdict.
    always_comb begin
        out_o.gt = loc_gt_i | (loc_eq_i & below_i.gt);
        out_o.lt = loc_lt_i | (loc_eq_i & below_i.lt);
        out_o.eq = loc_eq_i & below_i.eq;
    end
endmodule

// File: rtl/mcmp_slice.sv
// One cascadable comparator slice of W bits.
// Assumes the lower verdict comes from less significant bits.
module mcmp_slice
    import mcmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  verdict_t     below_i,
    output verdict_t     out_o
);
    logic l_gt, l_eq, l_lt;

    mcmp_local #(.W(W)) u_local (
        .a_i (a_i),
        .b_i (b_i),
        .gt_o(l_gt),
        .eq_o(l_eq),
        .lt_o(l_lt)
    );

    mcmp_merge u_merge (
        .loc_gt_i(l_gt),
        .loc_eq_i(l_eq),
        .loc_lt_i(l_lt),
        .below_i (below_i),
        .out_o   (out_o)
    );

    // Slice-level properties of the merged verdict.
    always_comb begin
        a_r4_eq_needs_match: assert (!out_o.eq || (a_i == b_i));
        a_r3_pass_through: assert ((a_i != b_i) || (out_o == below_i));
        a_r5_onehot_kept: assert (!$onehot(below_i) || $onehot(out_o));
    end
endmodule

// File: rtl/mcmp_chain.sv
// Comparator built from NUM_SLICES slices of SLICE_W bits.
// Slice 0 takes the lowest bits and the cascade ports.
// Each slice feeds its verdict to the next more significant slice.
module mcmp_chain
    import mcmp_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int TOTAL_W   = SLICE_W * NUM_SLICES
) (
    input  logic [TOTAL_W-1:0] opa_i,
    input  logic [TOTAL_W-1:0] opb_i,
    input  logic               cas_gt_i,
    input  logic               cas_eq_i,
    input  logic               cas_lt_i,
    output logic               gt_o,
    output logic               eq_o,
    output logic               lt_o
);
    // link[s] enters slice s; link[NUM_SLICES] is the final verdict.
    verdict_t link [NUM_SLICES+1];

    assign link[0] = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        mcmp_slice #(.W(SLICE_W)) u_slice (
            .a_i    (opa_i[s*SLICE_W +: SLICE_W]),
            .b_i    (opb_i[s*SLICE_W +: SLICE_W]),
            .below_i(link[s]),
            .out_o  (link[s+1])
        );
    end

    assign gt_o = link[NUM_SLICES].gt;
    assign eq_o = link[NUM_SLICES].eq;
    assign lt_o = link[NUM_SLICES].lt;

    // Full-width properties at the ports.
    always_comb begin
        a_r1_full_gt: assert (!(opa_i > opb_i) || (gt_o && !eq_o && !lt_o));
        a_r2_full_lt: assert (!(opa_i < opb_i) || (lt_o && !eq_o && !gt_o));
        a_r6_tied_equal: assert (!(cas_eq_i && !cas_gt_i && !cas_lt_i && opa_i == opb_i) || eq_o);
    end
endmodule

// File: tb/mcmp_chain_tb_top.sv
// Self-checking bench for mcmp_chain with a behavioural reference model.
module mcmp_chain_tb_top;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] opa, opb;
    logic cgt, ceq, clt;
    logic gt, eq, lt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected verdicts and tags, queued in drive order.
    logic [2:0] exp_q[$];
    string      tag_q[$];

    mcmp_chain dut_i (
        .opa_i(opa), .opb_i(opb),
        .cas_gt_i(cgt), .cas_eq_i(ceq), .cas_lt_i(clt),
        .gt_o(gt), .eq_o(eq), .lt_o(lt)
    );

    // Reference model: integer compare, then merge with the cascade inputs.
    function automatic logic [2:0] ref_model(int a, int b, logic g, logic e, logic l);
        if (a > b) return 3'b100;
        if (a < b) return 3'b001;
        return {g, e, l};
    endfunction

    task automatic apply(input int a, input int b, input logic [2:0] cas, input string tag);
        @(posedge clk);
        #1;
        opa = W'(a);
        opb = W'(b);
        {cgt, ceq, clt} = cas;
        exp_q.push_back(ref_model(a, b, cas[2], cas[1], cas[0]));
        tag_q.push_back(tag);
    endtask

    // Compare on every falling edge while results are queued.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({gt, eq, lt} !== e) begin
                errors++;
                $display("FAIL %s: a=%h b=%h cas=%b got %b expected %b",
                         t, opa, opb, {cgt, ceq, clt}, {gt, eq, lt}, e);
            end
            if ($onehot({cgt, ceq, clt})) begin
                checks++;
                if (!$onehot({gt, eq, lt})) begin
                    errors++;
                    $display("FAIL R5: got %b expected one-hot", {gt, eq, lt});
                end
            end
            if (opa != opb) begin
                checks++;
                if (eq !== 1'b0) begin
                    errors++;
                    $display("FAIL R4: eq=%b expected 0", eq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [2:0] TIE = 3'b010;
    localparam int MAXV = (1 << W) - 1;

    initial begin
        opa = '0;
        opb = '0;
        {cgt, ceq, clt} = TIE;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Check right after reset: zero operands with the tie give equal.
        apply(0, 0, TIE, "R6 reset");

        // R6: all-equal patterns.
        apply(MAXV, MAXV, TIE, "R6 equal max");
        apply('h5A5, 'h5A5, TIE, "R6 equal mid");

        // R1 and R2: zero against maximum, both directions.
        apply(MAXV, 0, TIE, "R1 max vs 0");
        apply(0, MAXV, TIE, "R2 0 vs max");

        // R7: operands that differ only in bit 0, and only at each slice's top bit.
        apply('h001, 'h000, TIE, "R7 lsb gt");
        apply('hABC, 'hABD, TIE, "R7 lsb lt");
        for (int s = 0; s < 3; s++) begin
            apply(1 << (4*s+3), 0, TIE, "R7 slice msb gt");
            apply('h111, 'h111 | (1 << (4*s+3)), TIE, "R7 slice msb lt");
        end

        // R6: a higher slice overrides an opposite lower-slice difference.
        apply('h10F, 'h0F0, TIE, "R6 high overrides");
        apply('h0F0, 'h10F, TIE, "R6 high overrides");
        apply('h2F0, 'h20F, TIE, "R6 mid overrides");
        apply('h20F, 'h2F0, TIE, "R6 mid overrides");

        // R3: equal operands pass every cascade pattern through.
        for (int c = 0; c < 8; c++) begin
            apply('h3C7, 'h3C7, 3'(c), "R3 pass-through");
            apply(0, 0, 3'(c), "R3 pass-through zero");
        end

        // R1 and R2: unequal operands ignore every cascade pattern.
        for (int c = 0; c < 8; c++) begin
            apply('h800, 'h7FF, 3'(c), "R1 ignore cascade");
            apply('h7FF, 'h800, 3'(c), "R2 ignore cascade");
        end

        // Random pairs: some forced equal, others free.
        for (int i = 0; i < 400; i++) begin
            int a, b;
            logic [2:0] c;
            a = $urandom_range(0, MAXV);
            b = (i % 5 == 0) ? a : $urandom_range(0, MAXV);
            c = (i % 3 == 0) ? 3'($urandom_range(0, 7)) : TIE;
            apply(a, b, c, (a > b) ? "R1 random" : (a < b) ? "R2 random" : "R3 random");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule